// File: doc/BRIEF.md
# Coarse Vector Sharer Directory Entry

This block holds the sharer record for one cache line in a directory-based coherence scheme for many cores. While only a few cores share the line, it keeps their exact core numbers in a small set of pointer slots. When a sharer arrives and every slot is already taken, the entry changes its encoding. It becomes a bit vector in which each bit stands for a region of consecutive cores. From then on the recorded set may hold more cores than really share the line, but it never leaves one out.

Each clock the entry accepts one operation with a core number: add a sharer, remove a sharer, or serve a write. On a write it reports, one cycle later, the set of cores that must be invalidated and the number of acknowledgements to wait for. It then restarts in exact mode with the writer as the only sharer. The pointer slots and the region vector share one storage field. With the default sizes the entry takes 11 bits, where a full map of 16 cores takes 16.

Top module: `cvdir_entry`

## Requirements
- R1: After reset the entry is in exact mode (`coarse_mode` = 0), `cover_mask` is all zero and `inv_valid` is 0.
- R2: In exact mode, adding a core that is not yet recorded while a pointer slot is free sets exactly that core's bit in `cover_mask`. Adding a core that is already recorded changes nothing. Operation codes on `op_code`: 2'b00 idle, 2'b01 add, 2'b10 remove, 2'b11 write.
- R3: In exact mode, removing a recorded core clears only its bit in `cover_mask`. Removing a core that is not recorded changes nothing.
- R4: In exact mode with all NUM_PTRS slots in use, adding a core that is not recorded sets `coarse_mode`. `cover_mask` then becomes the union of the regions of every recorded core and of the new core. The region of core c is c / REGION, and it covers cores region*REGION to region*REGION+REGION-1.
- R5: In coarse mode, adding a core sets every bit of that core's region in `cover_mask` and leaves the other bits unchanged.
- R6: In coarse mode, a remove has no effect: `cover_mask` and `coarse_mode` keep their values.
- R7: A write raises `inv_valid` for exactly the following cycle. In that cycle `inv_mask` equals the `cover_mask` that held before the write, and `inv_acks` equals the number of set bits in it. With no write, `inv_valid` stays 0.
- R8: After a write the entry is in exact mode, and `cover_mask` holds only the writer's bit.
- R9: `cover_mask` always includes every core that was added and not removed since the last write, plus the last writer.
- R10: An idle operation leaves `coarse_mode` and `cover_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_code | input | 2 | Operation: 00 idle, 01 add, 10 remove, 11 write |
| op_core | input | $clog2(NUM_CORES) | Core the operation refers to |
| coarse_mode | output | 1 | 1 while the entry uses the region vector |
| cover_mask | output | NUM_CORES | Cores the entry currently records as sharers |
| inv_valid | output | 1 | One-cycle strobe after a write |
| inv_mask | output | NUM_CORES | Invalidation destinations captured by the last write |
| inv_acks | output | $clog2(NUM_CORES+1) | Expected acknowledgement count for `inv_mask` |

## Verification
Directed sequences cover the cases that separate the two encodings. A duplicate add and a remove of a core that is not recorded must not disturb the exact pointers. The add that takes the entry past its pointer count must fold the pointers into region bits. A remove in coarse mode must be ignored. A write from coarse mode must return a mask padded to whole regions, and its acknowledgement count must be a multiple of REGION. Random mixes, weighted towards adds, drive the entry into and out of coarse mode many times. They check after every operation that the recorded set still covers every true sharer, which shows whether any path drops a core.

// File: rtl/cvdir_pkg.sv
`timescale 1ns/1ps
package cvdir_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ADD  = 2'b01,
    OP_DEL  = 2'b10,
    OP_WR   = 2'b11
  } dir_op_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cvdir_slots.sv
`timescale 1ns/1ps
// Compares an incoming core number with every pointer slot and finds the
// lowest free slot.
module cvdir_slots #(
  parameter int NUM_PTRS = 2,
  parameter int ID_W     = 4,
  parameter int IDX_W    = 1
) (
  input  logic [NUM_PTRS*ID_W-1:0] slot_ids,
  input  logic [NUM_PTRS-1:0]      slot_vld,
  input  logic [ID_W-1:0]          key,
  output logic [NUM_PTRS-1:0]      hit_vec,
  output logic                     any_hit,
  output logic                     has_free,
  output logic [IDX_W-1:0]         free_idx
);

  for (genvar s = 0; s < NUM_PTRS; s++) begin : g_cmp
    assign hit_vec[s] = slot_vld[s] && (slot_ids[s*ID_W +: ID_W] == key);
  end

  assign any_hit  = |hit_vec;
  assign has_free = ~&slot_vld;

  always_comb begin
    free_idx = '0;
    for (int s = NUM_PTRS - 1; s >= 0; s--) begin
      if (!slot_vld[s]) free_idx = IDX_W'(s);
    end
  end

endmodule

// File: rtl/cvdir_fold.sv
`timescale 1ns/1ps
// Converts the exact pointers into a region vector.
module cvdir_fold #(
  parameter int NUM_PTRS = 2,
  parameter int ID_W     = 4,
  parameter int REGIONS  = 8,
  parameter int REG_SH   = 1
) (
  input  logic [NUM_PTRS*ID_W-1:0] slot_ids,
  input  logic [NUM_PTRS-1:0]      slot_vld,
  output logic [REGIONS-1:0]       rvec
);

  for (genvar g = 0; g < REGIONS; g++) begin : g_reg
    logic [NUM_PTRS-1:0] in_reg;
    for (genvar s = 0; s < NUM_PTRS; s++) begin : g_slot
      assign in_reg[s] = slot_vld[s] &&
                         ((slot_ids[s*ID_W +: ID_W] >> REG_SH) == ID_W'(g));
    end
    assign rvec[g] = |in_reg;
  end

endmodule

// File: rtl/cvdir_expand.sv
`timescale 1ns/1ps
// Turns the stored encoding into a per-core mask and its population count.
module cvdir_expand #(
  parameter int NUM_CORES = 16,
  parameter int NUM_PTRS  = 2,
  parameter int ID_W      = 4,
  parameter int REGIONS   = 8,
  parameter int REG_SH    = 1,
  parameter int ACK_W     = 5
) (
  input  logic                     coarse,
  input  logic [NUM_PTRS*ID_W-1:0] slot_ids,
  input  logic [NUM_PTRS-1:0]      slot_vld,
  input  logic [REGIONS-1:0]       rvec,
  output logic [NUM_CORES-1:0]     cores,
  output logic [ACK_W-1:0]         count
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_PTRS-1:0] ptr_eq;
    for (genvar s = 0; s < NUM_PTRS; s++) begin : g_slot
      assign ptr_eq[s] = slot_vld[s] && (slot_ids[s*ID_W +: ID_W] == ID_W'(c));
    end
    assign cores[c] = coarse ? rvec[c >> REG_SH] : (|ptr_eq);
  end

  always_comb begin
    count = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      count = count + ACK_W'(cores[c]);
    end
  end

endmodule

// File: rtl/cvdir_entry.sv
`timescale 1ns/1ps
module cvdir_entry
  import cvdir_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int NUM_PTRS  = 2,
  parameter int REGION    = 2,
  localparam int ID_W     = $clog2(NUM_CORES),
  localparam int ACK_W    = $clog2(NUM_CORES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           op_code,
  input  logic [ID_W-1:0]      op_core,
  output logic                 coarse_mode,
  output logic [NUM_CORES-1:0] cover_mask,
  output logic                 inv_valid,
  output logic [NUM_CORES-1:0] inv_mask,
  output logic [ACK_W-1:0]     inv_acks
);

  localparam int SLOT_W   = ID_W + 1;
  localparam int REGIONS  = NUM_CORES / REGION;
  localparam int REG_SH   = $clog2(REGION);
  localparam int PTR_BITS = NUM_PTRS * SLOT_W;
  localparam int PAY_W    = max_int(PTR_BITS, REGIONS);
  localparam int IDX_W    = (NUM_PTRS > 1) ? $clog2(NUM_PTRS) : 1;

  // Reset: asserted at once, released two clocks later.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // State: mode flag plus one shared payload. In exact mode slot s is
  // {valid, id} at bits [s*SLOT_W +: SLOT_W]. In coarse mode bits
  // [REGIONS-1:0] hold the region vector.
  logic             mode_q, mode_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             inv_v_q, inv_v_d;
  logic [NUM_CORES-1:0] inv_m_q, inv_m_d;
  logic [ACK_W-1:0] inv_a_q, inv_a_d;
  logic             state_en, inv_en;

  logic [NUM_PTRS*ID_W-1:0] slot_ids;
  logic [NUM_PTRS-1:0]      slot_vld;
  logic [REGIONS-1:0]       rvec_q;

  for (genvar s = 0; s < NUM_PTRS; s++) begin : g_unpack
    assign slot_ids[s*ID_W +: ID_W] = pay_q[s*SLOT_W +: ID_W];
    assign slot_vld[s]              = pay_q[s*SLOT_W + ID_W];
  end
  assign rvec_q = pay_q[REGIONS-1:0];

  logic [NUM_PTRS-1:0] hit_vec;
  logic                any_hit;
  logic                has_free;
  logic [IDX_W-1:0]    free_idx;

  cvdir_slots #(
    .NUM_PTRS(NUM_PTRS), .ID_W(ID_W), .IDX_W(IDX_W)
  ) u_slots (
    .slot_ids (slot_ids),
    .slot_vld (slot_vld),
    .key      (op_core),
    .hit_vec  (hit_vec),
    .any_hit  (any_hit),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  logic [REGIONS-1:0] fold_vec;

  cvdir_fold #(
    .NUM_PTRS(NUM_PTRS), .ID_W(ID_W), .REGIONS(REGIONS), .REG_SH(REG_SH)
  ) u_fold (
    .slot_ids (slot_ids),
    .slot_vld (slot_vld),
    .rvec     (fold_vec)
  );

  logic [NUM_CORES-1:0] cur_cores;
  logic [ACK_W-1:0]     cur_count;

  cvdir_expand #(
    .NUM_CORES(NUM_CORES), .NUM_PTRS(NUM_PTRS), .ID_W(ID_W),
    .REGIONS(REGIONS), .REG_SH(REG_SH), .ACK_W(ACK_W)
  ) u_expand (
    .coarse   (mode_q),
    .slot_ids (slot_ids),
    .slot_vld (slot_vld),
    .rvec     (rvec_q),
    .cores    (cur_cores),
    .count    (cur_count)
  );

  dir_op_e            op;
  logic [REGIONS-1:0] new_reg;

  assign op      = dir_op_e'(op_code);
  assign new_reg = REGIONS'(1) << (op_core >> REG_SH);

  // Next-state logic
  always_comb begin
    mode_d   = mode_q;
    pay_d    = pay_q;
    inv_v_d  = 1'b0;
    inv_m_d  = inv_m_q;
    inv_a_d  = inv_a_q;
    state_en = 1'b0;
    inv_en   = 1'b0;
    case (op)
      OP_ADD: begin
        state_en = 1'b1;
        if (mode_q) begin
          pay_d[REGIONS-1:0] = rvec_q | new_reg;
        end else if (!any_hit) begin
          if (has_free) begin
            pay_d[free_idx*SLOT_W +: SLOT_W] = {1'b1, op_core};
          end else begin
            mode_d             = 1'b1;
            pay_d              = '0;
            pay_d[REGIONS-1:0] = fold_vec | new_reg;
          end
        end
      end
      OP_DEL: begin
        state_en = 1'b1;
        if (!mode_q) begin
          for (int s = 0; s < NUM_PTRS; s++) begin
            if (hit_vec[s]) pay_d[s*SLOT_W + ID_W] = 1'b0;
          end
        end
      end
      OP_WR: begin
        state_en            = 1'b1;
        inv_en              = 1'b1;
        inv_v_d             = 1'b1;
        inv_m_d             = cur_cores;
        inv_a_d             = cur_count;
        mode_d              = 1'b0;
        pay_d               = '0;
        pay_d[SLOT_W-1:0]   = {1'b1, op_core};
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= 1'b0;
      pay_q  <= '0;
    end else if (state_en) begin
      mode_q <= mode_d;
      pay_q  <= pay_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      inv_v_q <= 1'b0;
      inv_m_q <= '0;
      inv_a_q <= '0;
    end else begin
      inv_v_q <= inv_v_d;
      if (inv_en) begin
        inv_m_q <= inv_m_d;
        inv_a_q <= inv_a_d;
      end
    end
  end

  assign coarse_mode = mode_q;
  assign cover_mask  = cur_cores;
  assign inv_valid   = inv_v_q;
  assign inv_mask    = inv_m_q;
  assign inv_acks    = inv_a_q;

endmodule

// File: rtl/cvdir_entry_chk.sv
`timescale 1ns/1ps
module cvdir_entry_chk #(
  parameter int NUM_CORES = 16,
  parameter int NUM_PTRS  = 2,
  parameter int ID_W      = 4,
  parameter int ACK_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           op_code,
  input logic [ID_W-1:0]      op_core,
  input logic                 coarse_mode,
  input logic [NUM_CORES-1:0] cover_mask,
  input logic                 inv_valid,
  input logic [NUM_CORES-1:0] inv_mask,
  input logic [ACK_W-1:0]     inv_acks
);

  AST_EXACT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !coarse_mode |-> ($countones(cover_mask) <= NUM_PTRS)); // R2

  AST_COARSE_DEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_mode && op_code == 2'b10) |=> ($stable(cover_mask) && coarse_mode)); // R6

  AST_INV_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> ($past(op_code) == 2'b11)); // R7

  AST_NO_SPURIOUS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 2'b11) |=> !inv_valid); // R7

  AST_ACK_MATCHES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (32'(inv_acks) == $countones(inv_mask))); // R7

  AST_WRITER_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b11) |=>
      (!coarse_mode && cover_mask == (NUM_CORES'(1) << $past(op_core)))); // R8

  AST_ADD_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b01) |=> cover_mask[$past(op_core)]); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 2'b00) |=> ($stable(cover_mask) && $stable(coarse_mode))); // R10

endmodule

bind cvdir_entry cvdir_entry_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PTRS(NUM_PTRS), .ID_W(ID_W), .ACK_W(ACK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .op_code     (op_code),
  .op_core     (op_core),
  .coarse_mode (coarse_mode),
  .cover_mask  (cover_mask),
  .inv_valid   (inv_valid),
  .inv_mask    (inv_mask),
  .inv_acks    (inv_acks)
);

// File: tb/cvdir_entry_test.sv
`timescale 1ns/1ps
module cvdir_entry_test;

  localparam int NC    = 16;
  localparam int NP    = 2;
  localparam int RG    = 2;
  localparam int ID_W  = $clog2(NC);
  localparam int ACK_W = $clog2(NC + 1);
  localparam int NR    = NC / RG;

  logic             clk;
  logic             rst_n;
  logic [1:0]       op_code;
  logic [ID_W-1:0]  op_core;
  logic             coarse_mode;
  logic [NC-1:0]    cover_mask;
  logic             inv_valid;
  logic [NC-1:0]    inv_mask;
  logic [ACK_W-1:0] inv_acks;

  cvdir_entry #(.NUM_CORES(NC), .NUM_PTRS(NP), .REGION(RG)) uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_core(op_core),
    .coarse_mode(coarse_mode), .cover_mask(cover_mask),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_acks(inv_acks)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int fails = 0;

  // Reference state
  bit          m_coarse;
  bit [NC-1:0] m_emask;
  bit [NR-1:0] m_rvec;
  bit [NC-1:0] true_sh;

  function automatic bit [NC-1:0] expand_regions(input bit [NR-1:0] rv);
    bit [NC-1:0] m = '0;
    for (int c = 0; c < NC; c++) if (rv[c / RG]) m[c] = 1'b1;
    return m;
  endfunction

  function automatic bit [NR-1:0] fold_cores(input bit [NC-1:0] cm);
    bit [NR-1:0] r = '0;
    for (int c = 0; c < NC; c++) if (cm[c]) r[c / RG] = 1'b1;
    return r;
  endfunction

  function automatic bit [NC-1:0] model_cover();
    return m_coarse ? expand_regions(m_rvec) : m_emask;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] code, input int core);
    bit [NC-1:0] pre_cover = model_cover();
    string tag;
    bit exp_inv = 1'b0;
    @(negedge clk);
    op_code = code;
    op_core = ID_W'(core);
    case (code)
      2'b01: begin
        true_sh[core] = 1'b1;
        if (m_coarse) begin
          m_rvec[core / RG] = 1'b1;
          tag = "R5";
        end else if (m_emask[core]) begin
          tag = "R2";
        end else if ($countones(m_emask) < NP) begin
          m_emask[core] = 1'b1;
          tag = "R2";
        end else begin
          m_rvec = fold_cores(m_emask);
          m_rvec[core / RG] = 1'b1;
          m_emask  = '0;
          m_coarse = 1'b1;
          tag = "R4";
        end
      end
      2'b10: begin
        true_sh[core] = 1'b0;
        if (m_coarse) tag = "R6";
        else begin
          m_emask[core] = 1'b0;
          tag = "R3";
        end
      end
      2'b11: begin
        exp_inv  = 1'b1;
        m_coarse = 1'b0;
        m_emask  = '0;
        m_emask[core] = 1'b1;
        true_sh  = '0;
        true_sh[core] = 1'b1;
        tag = "R8";
      end
      default: tag = "R10";
    endcase
    @(posedge clk);
    #5;
    check(tag, "coarse_mode", longint'(coarse_mode), longint'(m_coarse));
    check(tag, "cover_mask", longint'(cover_mask), longint'(model_cover()));
    check("R7", "inv_valid", longint'(inv_valid), longint'(exp_inv));
    if (exp_inv) begin
      check("R7", "inv_mask", longint'(inv_mask), longint'(pre_cover));
      check("R7", "inv_acks", longint'(inv_acks), longint'($countones(pre_cover)));
    end
    check("R9", "cover superset", longint'(cover_mask & true_sh), longint'(true_sh));
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    op_code  = 2'b00;
    op_core  = '0;
    m_coarse = 1'b0;
    m_emask  = '0;
    m_rvec   = '0;
    true_sh  = '0;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "coarse_mode", longint'(coarse_mode), 0);
    check("R1", "cover_mask", longint'(cover_mask), 0);
    check("R1", "inv_valid", longint'(inv_valid), 0);

    // Directed corner cases
    step(2'b01, 1);    // R2 new pointer
    step(2'b01, 1);    // R2 duplicate
    step(2'b01, 5);    // R2 second pointer
    step(2'b10, 9);    // R3 remove of a non-sharer
    step(2'b10, 1);    // R3 remove
    step(2'b01, 1);    // R2 refill
    step(2'b01, 15);   // R4 overflow: cores 0,1,4,5,14,15
    check("R4", "overflow mask", longint'(cover_mask), longint'(16'hC033));
    step(2'b01, 8);    // R5 coarse add
    step(2'b10, 5);    // R6 ignored remove
    check("R6", "region kept", longint'(cover_mask[5]), 1);
    step(2'b00, 0);    // R10 idle
    step(2'b11, 3);    // R7 and R8: 8 acks
    check("R7", "coarse acks", longint'(inv_acks), 8);
    step(2'b00, 0);    // R7 strobe lasts one cycle
    step(2'b11, 3);    // R7 write from exact mode: 1 ack
    check("R7", "exact acks", longint'(inv_acks), 1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom % 10;
      int core = int'($urandom % NC);
      logic [1:0] code;
      if (r < 5)      code = 2'b01;
      else if (r < 8) code = 2'b10;
      else if (r < 9) code = 2'b11;
      else            code = 2'b00;
      step(code, core);
    end
    @(negedge clk);
    op_code = 2'b00;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule